// File: doc/BRIEF.md
# Peripheral quadrant write-protection checker

This block sits in front of a peripheral register space. It checks every bus write before the write reaches a peripheral. The byte address space is divided into peripheral selects of 1 KB each. Every select is split into four 256-byte quadrants. The block holds one protection bit per quadrant. A write from an unprivileged requester to a protected quadrant is stopped: it is not forwarded, and it is answered with an abort. Privileged traffic and all reads pass through unchanged.

Software programs the protection bits through a second, word-addressed register port. Each 32-bit group of bits has one write-one-to-set register and one write-one-to-clear register. Only privileged writes may change these registers. The block also keeps a sticky record of the first blocked write: its byte address and its quadrant index. This record stays until software clears it. Every access and every register request gets a registered response exactly one cycle later.

Top module: `qprot_guard`

## Requirements
- R1: After reset, every protection bit is 0. No access aborts, and the violation record reads as empty (both status words read 0).
- R2: The quadrant index of a byte address is 4 × select + quadrant. The select is address bits [ADDR_W-1:10] and the quadrant is address bits [9:8]. Register group k holds indices 32k to 32k+31, with index 32k+b at bit b. Group k therefore covers selects 8k to 8k+7.
- R3: A privileged write to word offset 2k (set register of group k) sets every protection bit whose data bit is 1. Bits whose data bit is 0 are left unchanged. A read of offset 2k or 2k+1 returns the current bits of group k.
- R4: A privileged write to word offset 2k+1 (clear register of group k) clears every protection bit whose data bit is 1. Bits whose data bit is 0 are left unchanged.
- R5: An unprivileged write to a quadrant whose bit is set gets acc_done and acc_abort one cycle after the request. fwd_valid stays low in that cycle.
- R6: A privileged write, or any write to an unprotected quadrant, is forwarded on the next cycle with the same write flag, address and data, and it does not abort.
- R7: Reads on the access port never abort and are always forwarded.
- R8: An unprivileged write to any register offset changes no state and returns reg_abort with its reg_ack. Reads of registers are allowed at either privilege level.
- R9: The first blocked write stores its byte address (read at offset 2·NREG) and its quadrant index (bits [IDX_W-1:0] at offset 2·NREG+1, with bit 31 as the valid flag). Later violations leave the record unchanged. A privileged write with bit 31 set to offset 2·NREG+1 clears the record. A violation in the same cycle as that clear is stored.
- R10: Every access request gets exactly one acc_done pulse, in the cycle after the request.
- R11: Every register request gets reg_ack in the next cycle. Reads of offsets beyond 2·NREG+1 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_valid | input | 1 | Register request strobe |
| reg_write | input | 1 | Register request is a write |
| reg_priv | input | 1 | Register requester is privileged |
| reg_addr | input | RA_W | Register word offset |
| reg_wdata | input | 32 | Register write data |
| reg_ack | output | 1 | Register response |
| reg_abort | output | 1 | Register write refused |
| reg_rdata | output | 32 | Register read data |
| acc_valid | input | 1 | Peripheral access strobe |
| acc_write | input | 1 | Access is a write |
| acc_priv | input | 1 | Access is privileged |
| acc_addr | input | ADDR_W | Byte address in peripheral space |
| acc_wdata | input | 32 | Access write data |
| fwd_valid | output | 1 | Access passed to peripheral |
| fwd_write | output | 1 | Forwarded write flag |
| fwd_addr | output | ADDR_W | Forwarded address |
| fwd_wdata | output | 32 | Forwarded data |
| acc_done | output | 1 | Access response |
| acc_abort | output | 1 | Access aborted by protection |
| viol_pending | output | 1 | Violation record holds an entry |

## Verification
On every cycle, the assertions check the following:
- The response follows the request by one cycle.
- An aborted write is never forwarded.
- Privileged accesses and reads never abort.
- A refused register write leaves the protection bits untouched.
- A held violation address stays fixed until cleared.

Only the bench's scenarios can show that the right bit guards the right quadrant. These scenarios also cover set and clear masking, the first-violation capture and its clearing, and read-back of each register group against a model driven by random and directed traffic.

// File: rtl/qprot_pkg.sv
package qprot_pkg;
  localparam int REG_W    = 32;
  localparam int QUAD_LOG = 8;
  localparam int SEL_LOG  = 10;

  typedef enum logic [2:0] {
    RK_SET,
    RK_CLR,
    RK_STAT_A,
    RK_STAT_F,
    RK_NONE
  } reg_kind_e;
endpackage

// File: rtl/qprot_regmap.sv
module qprot_regmap
  import qprot_pkg::*;
#(
  parameter int RA_W = 4,
  parameter int NREG = 2,
  parameter int KW   = 1
) (
  input  logic [RA_W-1:0] reg_addr,
  output reg_kind_e       kind,
  output logic [KW-1:0]   grp
);
  localparam int STAT_BASE = 2 * NREG;

  always_comb begin
    kind = RK_NONE;
    grp  = '0;
    if (int'(reg_addr) < STAT_BASE) begin
      kind = reg_addr[0] ? RK_CLR : RK_SET;
      grp  = KW'(reg_addr >> 1);
    end else if (int'(reg_addr) == STAT_BASE) begin
      kind = RK_STAT_A;
    end else if (int'(reg_addr) == STAT_BASE + 1) begin
      kind = RK_STAT_F;
    end
  end
endmodule

// File: rtl/qprot_bank.sv
module qprot_bank
  import qprot_pkg::*;
#(
  parameter int NQ   = 64,
  parameter int NREG = 2,
  parameter int KW   = 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             set_en,
  input  logic             clr_en,
  input  logic [KW-1:0]    grp,
  input  logic [REG_W-1:0] wdata,
  output logic [NQ-1:0]    prot,
  output logic [REG_W-1:0] rd_word
);
  localparam int PADW = NREG * REG_W;

  logic [PADW-1:0] set_pad, clr_pad, prot_pad;

  // One set mask and one clear mask lane per 32-bit register group.
  for (genvar g = 0; g < NREG; g++) begin : g_lane
    assign set_pad[g*REG_W +: REG_W] = (set_en && grp == KW'(g)) ? wdata : '0;
    assign clr_pad[g*REG_W +: REG_W] = (clr_en && grp == KW'(g)) ? wdata : '0;
  end

  always_comb begin
    prot_pad = '0;
    prot_pad[NQ-1:0] = prot;
  end

  assign rd_word = prot_pad[int'(grp)*REG_W +: REG_W];

  always_ff @(posedge clk) begin
    if (rst) prot <= '0;
    else     prot <= (prot | set_pad[NQ-1:0]) & ~clr_pad[NQ-1:0];
  end
endmodule

// File: rtl/qprot_access.sv
module qprot_access
  import qprot_pkg::*;
#(
  parameter int ADDR_W = 14,
  parameter int IDX_W  = 6,
  parameter int NQ     = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_priv,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [REG_W-1:0]  acc_wdata,
  input  logic [NQ-1:0]     prot,
  output logic              block,
  output logic [IDX_W-1:0]  blk_idx,
  output logic              fwd_valid,
  output logic              fwd_write,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [REG_W-1:0]  fwd_wdata,
  output logic              acc_done,
  output logic              acc_abort
);
  logic guarded;

  // Select and quadrant bits sit together at the top of the address.
  assign blk_idx = acc_addr[ADDR_W-1 -: IDX_W];
  assign guarded = (int'(blk_idx) < NQ) ? prot[blk_idx] : 1'b0;
  assign block   = acc_valid && acc_write && !acc_priv && guarded;

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_done  <= 1'b0;
      acc_abort <= 1'b0;
      fwd_valid <= 1'b0;
      fwd_write <= 1'b0;
      fwd_addr  <= '0;
      fwd_wdata <= '0;
    end else begin
      acc_done  <= acc_valid;
      acc_abort <= block;
      fwd_valid <= acc_valid && !block;
      if (acc_valid) begin
        fwd_write <= acc_write;
        fwd_addr  <= acc_addr;
        fwd_wdata <= acc_wdata;
      end
    end
  end
endmodule

// File: rtl/qprot_status.sv
module qprot_status #(
  parameter int ADDR_W = 14,
  parameter int IDX_W  = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hit,
  input  logic [ADDR_W-1:0] hit_addr,
  input  logic [IDX_W-1:0]  hit_idx,
  input  logic              clr,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [IDX_W-1:0]  idx
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
      idx   <= '0;
    end else if (hit && (!valid || clr)) begin
      valid <= 1'b1;
      addr  <= hit_addr;
      idx   <= hit_idx;
    end else if (clr) begin
      valid <= 1'b0;
      addr  <= '0;
      idx   <= '0;
    end
  end
endmodule

// File: rtl/qprot_guard.sv
module qprot_guard
  import qprot_pkg::*;
#(
  parameter int NUM_SEL = 16,
  parameter int RA_W    = 4,
  localparam int SEL_W  = (NUM_SEL > 1) ? $clog2(NUM_SEL) : 1,
  localparam int ADDR_W = SEL_W + SEL_LOG
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic              reg_priv,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic              reg_ack,
  output logic              reg_abort,
  output logic [31:0]       reg_rdata,
  input  logic              acc_valid,
  input  logic              acc_write,
  input  logic              acc_priv,
  input  logic [ADDR_W-1:0] acc_addr,
  input  logic [31:0]       acc_wdata,
  output logic              fwd_valid,
  output logic              fwd_write,
  output logic [ADDR_W-1:0] fwd_addr,
  output logic [31:0]       fwd_wdata,
  output logic              acc_done,
  output logic              acc_abort,
  output logic              viol_pending
);
  localparam int NQ    = 4 * NUM_SEL;
  localparam int NREG  = (NQ + REG_W - 1) / REG_W;
  localparam int KW    = (NREG > 1) ? $clog2(NREG) : 1;
  localparam int IDX_W = SEL_W + 2;

  reg_kind_e         kind;
  logic [KW-1:0]     grp;
  logic              wr_ok;
  logic              set_en, clr_en, stat_clr;
  logic [NQ-1:0]     prot_bits;
  logic [REG_W-1:0]  grp_word, rd_mux;
  logic              block;
  logic [IDX_W-1:0]  blk_idx;
  logic [ADDR_W-1:0] st_addr;
  logic [IDX_W-1:0]  st_idx;

  qprot_regmap #(.RA_W(RA_W), .NREG(NREG), .KW(KW)) u_map (
    .reg_addr(reg_addr), .kind(kind), .grp(grp)
  );

  assign wr_ok    = reg_valid && reg_write && reg_priv;
  assign set_en   = wr_ok && kind == RK_SET;
  assign clr_en   = wr_ok && kind == RK_CLR;
  assign stat_clr = wr_ok && kind == RK_STAT_F && reg_wdata[REG_W-1];

  qprot_bank #(.NQ(NQ), .NREG(NREG), .KW(KW)) u_bank (
    .clk(clk), .rst(rst), .set_en(set_en), .clr_en(clr_en), .grp(grp),
    .wdata(reg_wdata), .prot(prot_bits), .rd_word(grp_word)
  );

  qprot_access #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .NQ(NQ)) u_acc (
    .clk(clk), .rst(rst), .acc_valid(acc_valid), .acc_write(acc_write),
    .acc_priv(acc_priv), .acc_addr(acc_addr), .acc_wdata(acc_wdata),
    .prot(prot_bits), .block(block), .blk_idx(blk_idx),
    .fwd_valid(fwd_valid), .fwd_write(fwd_write), .fwd_addr(fwd_addr),
    .fwd_wdata(fwd_wdata), .acc_done(acc_done), .acc_abort(acc_abort)
  );

  qprot_status #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_stat (
    .clk(clk), .rst(rst), .hit(block), .hit_addr(acc_addr), .hit_idx(blk_idx),
    .clr(stat_clr), .valid(viol_pending), .addr(st_addr), .idx(st_idx)
  );

  always_comb begin
    rd_mux = '0;
    case (kind)
      RK_SET, RK_CLR: rd_mux = grp_word;
      RK_STAT_A:      rd_mux[ADDR_W-1:0] = st_addr;
      RK_STAT_F: begin
        rd_mux[REG_W-1]   = viol_pending;
        rd_mux[IDX_W-1:0] = st_idx;
      end
      default:        rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_ack   <= 1'b0;
      reg_abort <= 1'b0;
      reg_rdata <= '0;
    end else begin
      reg_ack   <= reg_valid;
      reg_abort <= reg_valid && reg_write && !reg_priv;
      reg_rdata <= (reg_valid && !reg_write) ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/qprot_guard_chk.sv
module qprot_guard_chk #(
  parameter int NQ     = 64,
  parameter int ADDR_W = 14
) (
  input logic              clk,
  input logic              rst,
  input logic              reg_valid,
  input logic              reg_write,
  input logic              reg_priv,
  input logic              acc_valid,
  input logic              acc_write,
  input logic              acc_priv,
  input logic              acc_done,
  input logic              acc_abort,
  input logic              fwd_valid,
  input logic              viol_pending,
  input logic              stat_clr,
  input logic [ADDR_W-1:0] st_addr,
  input logic [NQ-1:0]     prot_bits
);
  logic [1:0] age;
  logic       past_ok;

  always_ff @(posedge clk) begin
    if (rst) age <= '0;
    else if (!age[1]) age <= age + 2'd1;
  end
  assign past_ok = age[1];

  // R5
  abort_not_fwd_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_done && acc_abort) |-> !fwd_valid);

  // R10
  done_follows_req_chk: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> (acc_done == $past(acc_valid)));

  // R6
  priv_never_aborts_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && acc_done && $past(acc_priv)) |-> !acc_abort);

  // R7
  read_never_aborts_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && acc_done && !$past(acc_write)) |-> (!acc_abort && fwd_valid));

  // R8
  unpriv_reg_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && $past(reg_valid && reg_write && !reg_priv)) |-> (prot_bits == $past(prot_bits)));

  // R9
  record_held_chk: assert property (@(posedge clk) disable iff (rst)
    (past_ok && viol_pending && $past(viol_pending) && !$past(stat_clr)) |-> $stable(st_addr));
endmodule

bind qprot_guard qprot_guard_chk #(.NQ(NQ), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .reg_valid(reg_valid), .reg_write(reg_write),
  .reg_priv(reg_priv), .acc_valid(acc_valid), .acc_write(acc_write),
  .acc_priv(acc_priv), .acc_done(acc_done), .acc_abort(acc_abort),
  .fwd_valid(fwd_valid), .viol_pending(viol_pending), .stat_clr(stat_clr),
  .st_addr(st_addr), .prot_bits(prot_bits)
);

// File: tb/qprot_guard_test.sv
module qprot_guard_test;
  localparam int NUM_SEL = 16;
  localparam int RA_W    = 4;
  localparam int ADDR_W  = 14;
  localparam int IDX_W   = 6;
  localparam int NQ      = 64;
  localparam int NREG    = 2;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic              reg_valid = 0, reg_write = 0, reg_priv = 0;
  logic [RA_W-1:0]   reg_addr = '0;
  logic [31:0]       reg_wdata = '0;
  logic              reg_ack, reg_abort;
  logic [31:0]       reg_rdata;
  logic              acc_valid = 0, acc_write = 0, acc_priv = 0;
  logic [ADDR_W-1:0] acc_addr = '0;
  logic [31:0]       acc_wdata = '0;
  logic              fwd_valid, fwd_write, acc_done, acc_abort, viol_pending;
  logic [ADDR_W-1:0] fwd_addr;
  logic [31:0]       fwd_wdata;

  qprot_guard #(.NUM_SEL(NUM_SEL), .RA_W(RA_W)) uut (.*);

  int checks = 0, errors = 0;
  bit finished = 0;

  logic [NQ-1:0]     m_prot;
  logic              m_vv;
  logic [ADDR_W-1:0] m_va;
  logic [IDX_W-1:0]  m_vi;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [RA_W-1:0] a);
    logic [31:0] r = '0;
    if (int'(a) < 2 * NREG) r = m_prot[(int'(a) / 2) * 32 +: 32];
    else if (int'(a) == 2 * NREG) r[ADDR_W-1:0] = m_va;
    else if (int'(a) == 2 * NREG + 1) begin
      r[31] = m_vv;
      r[IDX_W-1:0] = m_vi;
    end
    return r;
  endfunction

  // Register request with checks of R8, R11 and read data against the model.
  task automatic reg_op(input string req, input bit w, input bit p,
                        input logic [RA_W-1:0] a, input logic [31:0] d);
    logic [31:0] e;
    e = w ? 32'h0 : exp_rd(a);
    @(negedge clk);
    reg_valid = 1; reg_write = w; reg_priv = p; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 0;
    chk({req, " R11 ack"}, 64'(reg_ack), 64'd1);
    chk({req, " R8 abort"}, 64'(reg_abort), 64'(w && !p));
    chk({req, " R3 rdata"}, 64'(reg_rdata), 64'(e));
    if (w && p) begin
      if (int'(a) < 2 * NREG) begin
        if (a[0]) m_prot[(int'(a) / 2) * 32 +: 32] &= ~d;
        else      m_prot[(int'(a) / 2) * 32 +: 32] |= d;
      end else if (int'(a) == 2 * NREG + 1 && d[31]) begin
        m_vv = 0; m_va = '0; m_vi = '0;
      end
    end
  endtask

  // Access request with checks of R2, R5, R6, R7, R10.
  task automatic acc_op(input string req, input bit w, input bit p,
                        input logic [ADDR_W-1:0] a, input logic [31:0] d);
    bit ab;
    ab = w && !p && m_prot[a[ADDR_W-1 -: IDX_W]];
    @(negedge clk);
    acc_valid = 1; acc_write = w; acc_priv = p; acc_addr = a; acc_wdata = d;
    @(negedge clk);
    acc_valid = 0;
    chk({req, " R10 done"}, 64'(acc_done), 64'd1);
    chk({req, " R5 abort"}, 64'(acc_abort), 64'(ab));
    chk({req, " R6 fwd_valid"}, 64'(fwd_valid), 64'(!ab));
    if (!ab) chk({req, " R6 fwd fields"}, {29'b0, fwd_write, fwd_addr, fwd_wdata[19:0]},
                 {29'b0, w, a, d[19:0]});
    if (ab && !m_vv) begin
      m_vv = 1; m_va = a; m_vi = a[ADDR_W-1 -: IDX_W];
    end
    chk({req, " R9 pending"}, 64'(viol_pending), 64'(m_vv));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    m_prot = '0; m_vv = 0; m_va = '0; m_vi = '0;
    repeat (4) @(posedge clk);
    @(negedge clk) rst = 0;
    // R1 reset state
    chk("R1 acc_done idle", 64'(acc_done), 64'd0);
    chk("R1 pending", 64'(viol_pending), 64'd0);
    for (int a = 0; a < 6; a++) reg_op("R1 read", 0, 0, RA_W'(a), 0);
    acc_op("R1 unpriv write", 1, 0, 14'h0000, 32'h1);
    // R3 set bits 0 and 4 (select 0 quadrant 0, select 1 quadrant 0)
    reg_op("R3 set", 1, 1, 4'd0, 32'h0000_0011);
    reg_op("R3 readback", 0, 0, 4'd0, 0);
    chk("R3 value", 64'(m_prot[31:0]), 64'h11);
    acc_op("R2 sel0 q0", 1, 0, 14'h0000, 32'hA);
    acc_op("R2 sel0 q0 top", 1, 0, 14'h00FF, 32'hB);
    acc_op("R2 sel0 q1", 1, 0, 14'h0100, 32'hC);
    acc_op("R2 sel1 q0", 1, 0, 14'h0400, 32'hD);
    // R9 first violation held
    reg_op("R9 addr", 0, 1, 4'd4, 0);
    reg_op("R9 flag", 0, 1, 4'd5, 0);
    chk("R9 held addr", 64'(m_va), 64'h0);
    acc_op("R6 priv write", 1, 1, 14'h0010, 32'hE);
    acc_op("R7 unpriv read", 0, 0, 14'h0020, 32'h0);
    // R8 unprivileged register write ignored
    reg_op("R8 unpriv set", 1, 0, 4'd0, 32'hFFFF_FFFF);
    reg_op("R8 readback", 0, 0, 4'd0, 0);
    // R4 clear
    reg_op("R4 clr", 1, 1, 4'd1, 32'h0000_0001);
    reg_op("R4 readback", 0, 1, 4'd1, 0);
    chk("R4 value", 64'(m_prot[31:0]), 64'h10);
    acc_op("R4 sel0 q0 free", 1, 0, 14'h0000, 32'hF);
    // R2 second group: select 8 quadrant 3
    reg_op("R2 set grp1", 1, 1, 4'd2, 32'h0000_0008);
    acc_op("R2 sel8 q3", 1, 0, 14'h2300, 32'h5);
    acc_op("R2 sel8 q2", 1, 0, 14'h2200, 32'h6);
    // R9 clear, then new capture
    reg_op("R9 clear", 1, 1, 4'd5, 32'h8000_0000);
    reg_op("R9 empty", 0, 1, 4'd5, 0);
    acc_op("R9 recapture", 1, 0, 14'h2304, 32'h7);
    reg_op("R9 new addr", 0, 1, 4'd4, 0);
    reg_op("R9 new flag", 0, 0, 4'd5, 0);
    reg_op("R11 unmapped", 0, 1, 4'd9, 0);
    // Random traffic
    for (int i = 0; i < 600; i++) begin
      logic [31:0] r;
      r = $urandom;
      if (r[0]) reg_op("rand reg", r[1], r[2], RA_W'(r[7:4] & 4'h7),
                       r[3] ? $urandom : (32'h1 << r[12:8]));
      else acc_op("rand acc", r[1], r[2], ADDR_W'($urandom), $urandom);
    end
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule